// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is a slave on a two-wire serial bus (I2C style) in front of a small byte-wide memory of 128 or 256 locations. It behaves like a serial EEPROM. A system clock much faster than the bus clock samples SCL and SDA through two-flop synchronisers. START and STOP conditions are found from the synchronised levels. The block shifts in a control byte, a word address and data bytes, most significant bit first. It answers with acknowledge bits and read data on an open-drain output: a high `sdaOutEn` pulls the line low.

Write data does not go into the array at once. Data bytes collect in a page buffer whose slot is picked by the low address bits, so a long write wraps within its page and later bytes overwrite earlier ones. The STOP that ends a write starts a self-timed programming cycle, counted in system clocks. The buffered bytes land in the array only when that cycle ends. While the cycle runs, the slave acknowledges nothing, so a master can poll it for completion. A write-protect input, sampled at STOP, stops the cycle from starting. Reads start at the current word address and step through the whole array.

Top module: `twi_eeprom`

## Requirements
- R1: A falling SDA while SCL is high is a START. It always returns the slave to control-byte reception, including mid-byte (repeated START), and drops the partial byte. A rising SDA while SCL is high is a STOP.
- R2: A control byte whose upper nibble (bits 7:4) is not 4'b1010 gets no acknowledge, and the slave ignores the bus until the next START. Bit 0 selects read (1) or write (0); bits 3:1 are not checked.
- R3: After an accepted control byte, a word address byte or a write data byte, the slave holds SDA low for the whole high time of the ninth SCL pulse.
- R4: The slave changes its SDA drive only while the synchronised SCL is low, apart from releasing it at a START or STOP.
- R5: A byte written and then read back by a random read (write control, address, repeated START, read control) returns the written value, shifted out MSB first.
- R6: A read returns the byte at the current word address and then increments the address. The address wraps from the top location to 0.
- R7: During a write, the word address increments only in its low 3 bits, so data crossing an 8-byte page boundary wraps to the start of the same page.
- R8: With more than 8 data bytes in one write, the 9th and later bytes replace the earliest buffered bytes in arrival order, and only the last 8 are stored.
- R9: The STOP that ends a write with at least one data byte starts a programming cycle of WRITE_CYCLES system clocks. No acknowledge is driven during the cycle, and the array is updated when it ends.
- R10: When the write-protect input is high at the STOP, no programming cycle starts and the array is unchanged. Acknowledges and reads work as normal.
- R11: When the master does not acknowledge a read byte, the slave releases SDA and returns to idle. A STOP after a read starts no write.
- R12: After reset, the slave does not drive SDA and every memory location reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired bus value) |
| wpIn | input | 1 | Write protect, high blocks programming |
| sdaOutEn | output | 1 | Open-drain drive: 1 pulls SDA low |

## Verification
The main function is tried with single-byte writes, page writes that start two bytes below a page boundary, and a ten-byte write into one page. Reading these back separates correct in-page wrap and oldest-first overwrite from a linear address counter or a buffer that drops late bytes. Back-to-back two-byte reads at address 0xFF followed by 0x00 show whether the read address wraps over the whole array rather than within a page. Polling with a control byte straight after a STOP tells a live programming cycle (no acknowledge) apart from a protected or aborted write (immediate acknowledge). Wrong device codes and a repeated START in the middle of a data byte show that only complete, matching transfers reach the array.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  // Device-type code expected in control byte bits 7:4
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_MACK
  } twiState_t;

  // Per-cycle commands from the bus controller to the datapath
  typedef struct packed {
    logic rxShift;   // shift one received bit in
    logic rxBit;     // value of that bit
    logic addrLoad;  // received byte becomes the word address
    logic bufPush;   // received byte goes into the page buffer
    logic rdLoad;    // fetch byte at word address, then step address
    logic txShift;   // move to the next transmit bit
    logic bufClear;  // discard buffered write data
    logic commit;    // start the programming cycle
  } twiStrobe_t;

endpackage

// File: rtl/twi_eeprom_ctrl.sv
module twi_eeprom_ctrl
  import twi_eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wpIn,
  input  logic       busy,
  input  logic       bufAny,
  input  logic       txBit,
  input  logic [3:0] devCode,
  input  logic       rwBit,
  output twiStrobe_t strb,
  output logic       sdaOutEn,
  output logic       sclSync,
  output logic       startEvt,
  output logic       stopEvt
);

  logic [1:0] sclPipe, sdaPipe;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS, sclRise, sclFall;

  twiState_t  st, stNext, after, afterNext;
  logic [3:0] bitCnt, bitNext;
  logic       ackDrv, ackNext;
  logic       mAck, mAckNext;

  // Two-flop synchronisers plus one stage of history for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclPrev <= sclPipe[1];
      sdaPrev <= sdaPipe[1];
    end
  end

  assign sclS     = sclPipe[1];
  assign sdaS     = sdaPipe[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startEvt = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEvt  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclSync  = sclS;

  always_comb begin
    stNext    = st;
    afterNext = after;
    bitNext   = bitCnt;
    ackNext   = ackDrv;
    mAckNext  = mAck;
    strb      = '0;
    strb.rxBit = sdaS;

    if (startEvt) begin
      stNext        = ST_CTRL;
      bitNext       = '0;
      ackNext       = 1'b0;
      strb.bufClear = 1'b1;
    end else if (stopEvt) begin
      stNext  = ST_IDLE;
      bitNext = '0;
      ackNext = 1'b0;
      if (st == ST_WDATA && bufAny && !wpIn && !busy)
        strb.commit = 1'b1;
    end else begin
      unique case (st)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (sclRise && bitCnt != 4'd8) begin
            strb.rxShift = 1'b1;
            bitNext      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitNext = '0;
            if (st == ST_CTRL) begin
              if (devCode == DEV_CODE && !busy) begin
                ackNext   = 1'b1;
                stNext    = ST_ACK;
                afterNext = rwBit ? ST_RDATA : ST_ADDR;
              end else begin
                stNext = ST_IDLE;
              end
            end else begin
              ackNext   = 1'b1;
              stNext    = ST_ACK;
              afterNext = ST_WDATA;
              if (st == ST_ADDR) strb.addrLoad = 1'b1;
              else               strb.bufPush  = 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ackNext = 1'b0;
            stNext  = after;
            bitNext = '0;
            if (after == ST_RDATA) strb.rdLoad = 1'b1;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stNext  = ST_MACK;
              bitNext = '0;
            end else begin
              strb.txShift = 1'b1;
              bitNext      = bitCnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) mAckNext = ~sdaS;
          if (sclFall) begin
            if (mAck) begin
              strb.rdLoad = 1'b1;
              stNext      = ST_RDATA;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      after  <= ST_IDLE;
      bitCnt <= '0;
      ackDrv <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      st     <= stNext;
      after  <= afterNext;
      bitCnt <= bitNext;
      ackDrv <= ackNext;
      mAck   <= mAckNext;
    end
  end

  assign sdaOutEn = ackDrv | ((st == ST_RDATA) & ~txBit);

endmodule

// File: rtl/twi_eeprom_dp.sv
module twi_eeprom_dp
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_DEPTH    = 256,
  parameter int PAGE_SIZE    = 8,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  twiStrobe_t strb,
  output logic [3:0] devCode,
  output logic       rwBit,
  output logic       txBit,
  output logic       busy,
  output logic       bufAny,
  output logic       memWe
);

  localparam int ADDR_W = $clog2(MEM_DEPTH);
  localparam int PG_W   = $clog2(PAGE_SIZE);
  localparam int BASE_W = ADDR_W - PG_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  logic [7:0]        rxReg, txReg;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        pageBuf [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] bufValid;
  logic [BASE_W-1:0] pageBase;
  logic [CNT_W-1:0]  busyCnt;
  logic [7:0]        mem [MEM_DEPTH];
  logic              clearOk;

  assign busy    = (busyCnt != '0);
  assign memWe   = (busyCnt == CNT_W'(1));
  assign bufAny  = |bufValid;
  assign clearOk = strb.bufClear & ~busy;
  assign devCode = rxReg[7:4];
  assign rwBit   = rxReg[0];
  assign txBit   = txReg[7];

  // Shift registers and word address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg <= '0;
      txReg <= 8'hFF;
      addr  <= '0;
    end else begin
      if (strb.rxShift) rxReg <= {rxReg[6:0], strb.rxBit};
      if (strb.txShift) txReg <= {txReg[6:0], 1'b1};
      if (strb.addrLoad) begin
        addr <= rxReg[ADDR_W-1:0];
      end else if (strb.bufPush) begin
        addr <= {addr[ADDR_W-1:PG_W], addr[PG_W-1:0] + PG_W'(1)};
      end else if (strb.rdLoad) begin
        txReg <= mem[addr];
        addr  <= addr + ADDR_W'(1);
      end
    end
  end

  // Page buffer slots, one per in-page offset
  for (genvar g = 0; g < PAGE_SIZE; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pageBuf[g]  <= '0;
        bufValid[g] <= 1'b0;
      end else if (clearOk || memWe) begin
        bufValid[g] <= 1'b0;
      end else if (strb.bufPush && !busy && addr[PG_W-1:0] == PG_W'(g)) begin
        pageBuf[g]  <= rxReg;
        bufValid[g] <= 1'b1;
      end
    end
  end

  // Self-timed programming cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt  <= '0;
      pageBase <= '0;
    end else if (strb.commit && !busy) begin
      busyCnt  <= CNT_W'(WRITE_CYCLES);
      pageBase <= addr[ADDR_W-1:PG_W];
    end else if (busy) begin
      busyCnt <= busyCnt - CNT_W'(1);
    end
  end

  // Array: buffered bytes land at the end of the cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (memWe) begin
      for (int i = 0; i < PAGE_SIZE; i++)
        if (bufValid[i]) mem[{pageBase, PG_W'(i)}] <= pageBuf[i];
    end
  end

endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_DEPTH    = 256,
  parameter int PAGE_SIZE    = 8,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaOutEn
);

  twiStrobe_t strb;
  logic [3:0] devCode;
  logic       rwBit, txBit, busy, bufAny, memWe;
  logic       sclSync, startEvt, stopEvt;

  twi_eeprom_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .wpIn     (wpIn),
    .busy     (busy),
    .bufAny   (bufAny),
    .txBit    (txBit),
    .devCode  (devCode),
    .rwBit    (rwBit),
    .strb     (strb),
    .sdaOutEn (sdaOutEn),
    .sclSync  (sclSync),
    .startEvt (startEvt),
    .stopEvt  (stopEvt)
  );

  twi_eeprom_dp #(
    .MEM_DEPTH    (MEM_DEPTH),
    .PAGE_SIZE    (PAGE_SIZE),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .devCode (devCode),
    .rwBit   (rwBit),
    .txBit   (txBit),
    .busy    (busy),
    .bufAny  (bufAny),
    .memWe   (memWe)
  );

endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk (
  input logic clk,
  input logic rstN,
  input logic sdaOutEn,
  input logic sclSync,
  input logic startEvt,
  input logic stopEvt,
  input logic busy,
  input logic wpIn
);

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdaOutEn) |-> (!sclSync || $past(startEvt) || $past(stopEvt))); // R4

  AST_SILENT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOutEn); // R9

  AST_CYCLE_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEvt)); // R9

  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(wpIn)); // R10

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopEvt) |-> !sdaOutEn); // R11

endmodule

bind twi_eeprom twi_eeprom_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sdaOutEn (sdaOutEn),
  .sclSync  (sclSync),
  .startEvt (startEvt),
  .stopEvt  (stopEvt),
  .busy     (busy),
  .wpIn     (wpIn)
);

// File: tb/tb_twi_eeprom.sv
module tb_twi_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;     // quarter SCL period in clocks
  localparam int WCYC       = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wpIn = 1'b0;
  logic sdaOutEn;
  logic sdaLine;

  int checks = 0;
  int errors = 0;

  assign sdaLine = sdaM & ~sdaOutEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_eeprom #(.MEM_DEPTH(256), .PAGE_SIZE(8), .WRITE_CYCLES(WCYC)) dut (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclM),
    .sdaIn    (sdaLine),
    .wpIn     (wpIn),
    .sdaOutEn (sdaOutEn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
    waitQ();
  endtask

  task automatic bitXfer(input logic b, output logic s);
    sdaM = b;    waitQ();
    sclM = 1'b1; waitQ();
    s = sdaLine; waitQ();
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitXfer(b[i], s);
    bitXfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitXfer(1'b1, s);
      d[i] = s;
    end
    bitXfer(~giveAck, s);
    sdaM = 1'b1;
  endtask

  task automatic setAddrForRead(input logic [7:0] a);
    logic ack;
    busStart();
    sendByte(8'hA0, ack);
    sendByte(a, ack);
    busStart();
    sendByte(8'hA1, ack);
  endtask

  task automatic readAt(input logic [7:0] a, output logic [7:0] d);
    setAddrForRead(a);
    recvByte(1'b0, d);
    busStop();
  endtask

  task automatic byteWrite(input logic [7:0] a, input logic [7:0] v, input logic doWait);
    logic ack;
    busStart();
    sendByte(8'hA0, ack); check("R3 ctrl ack", {7'd0, ack}, 8'd1);
    sendByte(a, ack);     check("R3 addr ack", {7'd0, ack}, 8'd1);
    sendByte(v, ack);     check("R3 data ack", {7'd0, ack}, 8'd1);
    busStop();
    if (doWait) repeat (WCYC + 50) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R12 sda released", {7'd0, sdaOutEn}, 8'd0);
    readAt(8'h00, d); check("R12 mem zero 00", d, 8'h00);
    readAt(8'h80, d); check("R12 mem zero 80", d, 8'h00);
  endtask

  task automatic testByteWrite();
    logic [7:0] d;
    logic ack;
    byteWrite(8'h10, 8'hA5, 1'b0);
    busStart();
    sendByte(8'hA0, ack);
    check("R9 no ack while busy", {7'd0, ack}, 8'd0);
    busStop();
    repeat (WCYC + 50) @(negedge clk);
    readAt(8'h10, d); check("R5 read back", d, 8'hA5);
  endtask

  task automatic testBadCode();
    logic ack;
    busStart();
    sendByte(8'h70, ack); check("R2 code 0111 nack", {7'd0, ack}, 8'd0);
    busStop();
    busStart();
    sendByte(8'hB1, ack); check("R2 code 1011 nack", {7'd0, ack}, 8'd0);
    busStop();
    busStart();
    sendByte(8'hAE, ack); check("R2 ignored low bits ack", {7'd0, ack}, 8'd1);
    busStop();
  endtask

  task automatic testPageWrap();
    logic [7:0] d;
    logic ack;
    busStart();
    sendByte(8'hA0, ack);
    sendByte(8'h1E, ack);
    for (int k = 1; k <= 4; k++) sendByte(8'(k), ack);
    busStop();
    repeat (WCYC + 50) @(negedge clk);
    readAt(8'h1E, d); check("R7 1E", d, 8'h01);
    readAt(8'h1F, d); check("R7 1F", d, 8'h02);
    readAt(8'h18, d); check("R7 18 wrapped", d, 8'h03);
    readAt(8'h19, d); check("R7 19 wrapped", d, 8'h04);
    readAt(8'h20, d); check("R7 next page untouched", d, 8'h00);
  endtask

  task automatic testOverwrite();
    logic [7:0] d;
    logic ack;
    busStart();
    sendByte(8'hA0, ack);
    sendByte(8'h40, ack);
    for (int k = 0; k < 10; k++) sendByte(8'h50 + 8'(k), ack);
    busStop();
    repeat (WCYC + 50) @(negedge clk);
    readAt(8'h40, d); check("R8 slot0 replaced", d, 8'h58);
    readAt(8'h41, d); check("R8 slot1 replaced", d, 8'h59);
    readAt(8'h42, d); check("R8 slot2 kept", d, 8'h52);
    readAt(8'h47, d); check("R8 slot7 kept", d, 8'h57);
  endtask

  task automatic testReadWrap();
    logic [7:0] d;
    byteWrite(8'h00, 8'h11, 1'b1);
    byteWrite(8'hFF, 8'hEE, 1'b1);
    setAddrForRead(8'hFF);
    recvByte(1'b1, d); check("R6 top byte", d, 8'hEE);
    recvByte(1'b0, d); check("R6 wrap to 00", d, 8'h11);
    busStop();
    setAddrForRead(8'h1E);
    recvByte(1'b1, d); check("R6 seq 1E", d, 8'h01);
    recvByte(1'b1, d); check("R6 seq 1F", d, 8'h02);
    recvByte(1'b0, d); check("R6 seq crosses page 20", d, 8'h00);
    busStop();
  endtask

  task automatic testWriteProtect();
    logic [7:0] d;
    logic ack;
    wpIn = 1'b1;
    busStart();
    sendByte(8'hA0, ack); check("R10 ctrl ack", {7'd0, ack}, 8'd1);
    sendByte(8'h10, ack); check("R10 addr ack", {7'd0, ack}, 8'd1);
    sendByte(8'h5A, ack); check("R10 data ack", {7'd0, ack}, 8'd1);
    busStop();
    busStart();
    sendByte(8'hA0, ack); check("R10 no cycle started", {7'd0, ack}, 8'd1);
    busStop();
    readAt(8'h10, d); check("R10 memory unchanged", d, 8'hA5);
    wpIn = 1'b0;
  endtask

  task automatic testNackStop();
    logic [7:0] d;
    logic ack;
    setAddrForRead(8'h42);
    recvByte(1'b0, d); check("R11 read byte", d, 8'h52);
    waitQ();
    check("R11 sda released after nack", {7'd0, sdaOutEn}, 8'd0);
    busStop();
    busStart();
    sendByte(8'hA0, ack); check("R11 no write after read stop", {7'd0, ack}, 8'd1);
    busStop();
  endtask

  task automatic testRepStart();
    logic [7:0] d;
    logic ack, s;
    busStart();
    sendByte(8'hA0, ack);
    sendByte(8'h20, ack);
    for (int i = 0; i < 4; i++) bitXfer(1'b1, s);
    busStart();
    sendByte(8'hA1, ack); check("R1 ctrl after repeated start", {7'd0, ack}, 8'd1);
    recvByte(1'b0, d);    check("R1 read at loaded address", d, 8'h00);
    busStop();
    busStart();
    sendByte(8'hA0, ack); check("R1 aborted byte not committed", {7'd0, ack}, 8'd1);
    busStop();
    readAt(8'h20, d); check("R1 memory untouched", d, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testByteWrite();
    testBadCode();
    testPageWrap();
    testOverwrite();
    testReadWrap();
    testWriteProtect();
    testNackStop();
    testRepStart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule